// File: doc/BRIEF.md
# Serial EEPROM Bus Front End with Write-Protection Control

This block is the two-wire slave front end of a small serial EEPROM. It synchronises SCL and SDA to the system clock and finds START and STOP conditions. It shifts in each byte most significant bit first and drives the acknowledge bit through an open-drain enable. The first byte after a START is the address byte. Its upper nibble is a device code, the next three bits are compared with the address-pin levels, and bit 0 selects read or write.

The address pins have a second use. Each pin gives a logic level and also a flag for an overvoltage level. Under the protection device code, the pin pattern selects one of three instructions: set the reversible protection, clear the reversible protection, or set the permanent protection. A protection write is a fixed three-byte sequence, and it takes effect only at the STOP that ends it. Once permanent protection is set, no protection write is acknowledged again. A normal-array write moves each data byte to the memory side through a one-cycle strobe. While either protection flag is set, a write into the lower half of the array is refused.

Top module: `eewp_front`

## Requirements
- R1: Bytes are sampled on rising SCL, most significant bit first. START (SDA falling while SCL is high) always restarts address reception. STOP (SDA rising while SCL is high) always ends the transaction.
- R2: An address byte with code 1010b in bits 7..4 and bits 3..1 equal to the effective pin value (pin level OR overvoltage flag, bit 3 matching pin 2) is acknowledged. With any other value in bits 3..1 it is not acknowledged.
- R3: An address byte whose code is neither 1010b nor 0110b is never acknowledged.
- R4: Set-reversible is code 0110b with pin 2 low, pin 1 low, pin 0 overvoltage (byte 0x62). With permanent protection clear, its address byte and two don't-care bytes are acknowledged, and the STOP that follows sets rev_prot to 1. Under code 0110b, a pin pattern that fits none of the three instructions is not acknowledged.
- R5: Clear-reversible is the same instruction with pin 1 high (byte 0x66). The completed sequence clears rev_prot at the STOP.
- R6: Permanent protection is code 0110b with no overvoltage flag and bits 3..1 equal to the pin levels, R/W = 0. The completed sequence sets perm_prot, and perm_prot then stays 1 until reset.
- R7: While perm_prot is 1, no protection write address byte (set-reversible, clear-reversible or permanent) is acknowledged, and neither flag changes.
- R8: A protection sequence cut short by a STOP or by a repeated START before all three bytes are acknowledged leaves both flags unchanged.
- R9: A protection status read (R/W = 1) is acknowledged only while the addressed flag is 0. The reversible patterns read rev_prot and the permanent pattern reads perm_prot.
- R10: While either flag is 1, a normal-write data byte whose word address has bit 7 = 0 is not acknowledged and gives no mem_wr. A data byte at word address 0x80 or above is still accepted.
- R11: Each acknowledged normal-write data byte pulses mem_wr for one cycle, with mem_addr equal to the word address and mem_wdata equal to the byte. The word address then increments by one. An acknowledged normal-read address pulses mem_rd once.
- R12: sda_oe is asserted only in the acknowledge bit of an acknowledged byte and is released after that bit ends.
- R13: After reset, rev_prot, perm_prot, sda_oe, mem_wr and mem_rd are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| pin_lvl | input | 3 | Logic level of address pins 2..0 |
| pin_hv | input | 3 | Overvoltage flag of address pins 2..0 |
| rev_prot | output | 1 | Reversible protection flag |
| perm_prot | output | 1 | Permanent protection flag |
| mem_wr | output | 1 | One-cycle write strobe to the array |
| mem_rd | output | 1 | One-cycle read-start strobe to the array |
| mem_addr | output | 8 | Word address for mem_wr |
| mem_wdata | output | 8 | Data byte for mem_wr |

## Verification
A wrong controller state or a wrong flag shows up in the acknowledge bit of the very next address or data byte. That bit is a ninth-bit check visible on the bus within one byte time, for example a protection write still acknowledged after permanent protection or a refused write to the lower half. A flag updated early or left stale also appears at once on rev_prot or perm_prot after the STOP, so short and broken sequences are run back to back with full ones. A bit-counter slip shows as a misplaced acknowledge or a misassembled address byte, and it is caught by the first decoded address.

// File: rtl/eewp_pkg.sv
package eewp_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] CODE_MEM  = 4'b1010;
  localparam logic [3:0] CODE_PROT = 4'b0110;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_PWA, ST_PWD, ST_PEND, ST_NWA, ST_NWD, ST_SKIP
  } ctl_st_t;

  typedef enum logic [1:0] {
    CMD_NONE, CMD_SETREV, CMD_CLRREV, CMD_PERM
  } pcmd_t;
endpackage

// File: rtl/eewp_sync.sv
module eewp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_sh, sda_sh, scl_sh_n, sda_sh_n;
  logic scl_p, sda_p, scl_s;

  always_comb begin
    scl_sh_n = {scl_sh[STAGES-2:0], scl_i};
    sda_sh_n = {sda_sh[STAGES-2:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= scl_sh_n;
      sda_sh <= sda_sh_n;
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/eewp_byte_rx.sv
module eewp_byte_rx
  import eewp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              sda_s,
  input  logic              ack_req,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_q,
  output logic              ack_done,
  output logic              ack_given,
  output logic              sda_oe
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] CNT_LASTBIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_ACK     = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_TAIL    = CNT_W'(BYTE_W + 1);

  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic drv_q, drv_n, bv_q, bv_n, ad_q, ad_n, ag_q, ag_n;

  always_comb begin
    cnt_n = cnt_q;
    sh_n  = sh_q;
    drv_n = drv_q;
    bv_n  = 1'b0;
    ad_n  = 1'b0;
    ag_n  = ag_q;
    if (start_evt || stop_evt) begin
      cnt_n = '0;
      drv_n = 1'b0;
    end else if (scl_rise) begin
      if (cnt_q < CNT_ACK) begin
        sh_n  = {sh_q[BYTE_W-2:0], sda_s};
        cnt_n = cnt_q + 1'b1;
        bv_n  = (cnt_q == CNT_LASTBIT);
      end else if (cnt_q == CNT_ACK) begin
        cnt_n = CNT_TAIL;
        ad_n  = 1'b1;
        ag_n  = drv_q;
      end
    end else if (scl_fall) begin
      if (cnt_q == CNT_ACK) begin
        drv_n = ack_req;
      end else if (cnt_q == CNT_TAIL) begin
        drv_n = 1'b0;
        cnt_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
      drv_q <= 1'b0;
      bv_q  <= 1'b0;
      ad_q  <= 1'b0;
      ag_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      sh_q  <= sh_n;
      drv_q <= drv_n;
      bv_q  <= bv_n;
      ad_q  <= ad_n;
      ag_q  <= ag_n;
    end
  end

  assign byte_valid = bv_q;
  assign byte_q     = sh_q;
  assign ack_done   = ad_q;
  assign ack_given  = ag_q;
  assign sda_oe     = drv_q;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_TAIL); // R1
  AST_ACK_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    drv_q |-> (cnt_q >= CNT_ACK)); // R12
  AST_RELEASE_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !drv_q); // R12
endmodule

// File: rtl/eewp_ctrl.sv
module eewp_ctrl
  import eewp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_q,
  input  logic              ack_done,
  input  logic              ack_given,
  input  logic [2:0]        pin_lvl,
  input  logic [2:0]        pin_hv,
  output logic              ack_req,
  output logic              rev_prot,
  output logic              perm_prot,
  output logic              mem_wr,
  output logic              mem_rd,
  output logic [BYTE_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata
);
  ctl_st_t st_q, st_n, go_q, go_n;
  pcmd_t   cmd_q, cmd_n, kind;
  logic    ack_q, ack_n, rev_q, rev_n, perm_q, perm_n;
  logic    rdf_q, rdf_n, wr_q, wr_n, rd_q, rd_n;
  logic [BYTE_W-1:0] hold_q, hold_n, wa_q, wa_n, ma_q, ma_n, md_q, md_n;

  logic [3:0] code;
  logic [2:0] sel, eff;
  logic       rw, sel_ok, blocked;

  always_comb begin
    code   = byte_q[7:4];
    sel    = byte_q[3:1];
    rw     = byte_q[0];
    eff    = pin_lvl | pin_hv;
    sel_ok = (sel == eff);
    if (pin_hv == 3'b001 && !pin_lvl[2])
      kind = pin_lvl[1] ? CMD_CLRREV : CMD_SETREV;
    else if (pin_hv == 3'b000)
      kind = CMD_PERM;
    else
      kind = CMD_NONE;
    blocked = (rev_q || perm_q) && !wa_q[BYTE_W-1];
  end

  always_comb begin
    st_n   = st_q;
    go_n   = go_q;
    cmd_n  = cmd_q;
    ack_n  = ack_q;
    rev_n  = rev_q;
    perm_n = perm_q;
    rdf_n  = rdf_q;
    hold_n = hold_q;
    wa_n   = wa_q;
    ma_n   = ma_q;
    md_n   = md_q;
    wr_n   = 1'b0;
    rd_n   = 1'b0;
    if (start_evt) begin
      st_n  = ST_ADDR;
      ack_n = 1'b0;
      rdf_n = 1'b0;
    end else if (stop_evt) begin
      if (st_q == ST_PEND) begin
        case (cmd_q)
          CMD_SETREV: rev_n  = 1'b1;
          CMD_CLRREV: rev_n  = 1'b0;
          CMD_PERM:   perm_n = 1'b1;
          default:    ;
        endcase
      end
      st_n  = ST_IDLE;
      ack_n = 1'b0;
    end else if (byte_valid) begin
      hold_n = byte_q;
      go_n   = ST_SKIP;
      ack_n  = 1'b0;
      rdf_n  = 1'b0;
      case (st_q)
        ST_ADDR: begin
          if (code == CODE_MEM && sel_ok) begin
            ack_n = 1'b1;
            rdf_n = rw;
            go_n  = rw ? ST_SKIP : ST_NWA;
          end else if (code == CODE_PROT && sel_ok && kind != CMD_NONE) begin
            cmd_n = kind;
            if (!rw) begin
              ack_n = !perm_q;
              go_n  = ST_PWA;
            end else begin
              ack_n = (kind == CMD_PERM) ? !perm_q : !rev_q;
            end
          end
        end
        ST_PWA: begin ack_n = 1'b1; go_n = ST_PWD;  end
        ST_PWD: begin ack_n = 1'b1; go_n = ST_PEND; end
        ST_NWA: begin ack_n = 1'b1; go_n = ST_NWD;  end
        ST_NWD: begin ack_n = !blocked; go_n = ST_NWD; end
        default: ;
      endcase
    end else if (ack_done) begin
      ack_n = 1'b0;
      if (ack_given) begin
        st_n = go_q;
        if (st_q == ST_NWA) wa_n = hold_q;
        if (st_q == ST_NWD) begin
          wr_n = 1'b1;
          ma_n = wa_q;
          md_n = hold_q;
          wa_n = wa_q + 1'b1;
        end
        rd_n = rdf_q;
      end else begin
        st_n = ST_SKIP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      go_q   <= ST_SKIP;
      cmd_q  <= CMD_NONE;
      ack_q  <= 1'b0;
      rev_q  <= 1'b0;
      perm_q <= 1'b0;
      rdf_q  <= 1'b0;
      hold_q <= '0;
      wa_q   <= '0;
      ma_q   <= '0;
      md_q   <= '0;
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      go_q   <= go_n;
      cmd_q  <= cmd_n;
      ack_q  <= ack_n;
      rev_q  <= rev_n;
      perm_q <= perm_n;
      rdf_q  <= rdf_n;
      hold_q <= hold_n;
      wa_q   <= wa_n;
      ma_q   <= ma_n;
      md_q   <= md_n;
      wr_q   <= wr_n;
      rd_q   <= rd_n;
    end
  end

  assign ack_req   = ack_q;
  assign rev_prot  = rev_q;
  assign perm_prot = perm_q;
  assign mem_wr    = wr_q;
  assign mem_rd    = rd_q;
  assign mem_addr  = ma_q;
  assign mem_wdata = md_q;

  AST_PERM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    perm_q |=> perm_q); // R6
  AST_FLAG_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (rev_q != $past(rev_q)) |-> $past(stop_evt)); // R8
  AST_NO_BLOCKED_WR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> (ma_q[BYTE_W-1] || !(rev_q || perm_q))); // R10
  AST_PROT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PWA) |-> !perm_q); // R7
endmodule

// File: rtl/eewp_front.sv
module eewp_front
  import eewp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] pin_lvl,
  input  logic [2:0] pin_hv,
  output logic       rev_prot,
  output logic       perm_prot,
  output logic       mem_wr,
  output logic       mem_rd,
  output logic [7:0] mem_addr,
  output logic [7:0] mem_wdata
);
  logic [1:0] rsync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic byte_valid, ack_done, ack_given, ack_req;
  logic [BYTE_W-1:0] byte_q;

  eewp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  eewp_byte_rx u_rx (
    .clk(clk), .rst_n(rst_n_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_s(sda_s),
    .ack_req(ack_req), .byte_valid(byte_valid), .byte_q(byte_q),
    .ack_done(ack_done), .ack_given(ack_given), .sda_oe(sda_oe)
  );

  eewp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .start_evt(start_evt), .stop_evt(stop_evt),
    .byte_valid(byte_valid), .byte_q(byte_q), .ack_done(ack_done),
    .ack_given(ack_given), .pin_lvl(pin_lvl), .pin_hv(pin_hv),
    .ack_req(ack_req), .rev_prot(rev_prot), .perm_prot(perm_prot),
    .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );
endmodule

// File: tb/eewp_front_test.sv
module eewp_front_test;
  localparam int Q = 6;

  logic clk, rst_n, scl, sda_m;
  logic [2:0] pin_lvl, pin_hv;
  logic sda_oe, rev_prot, perm_prot, mem_wr, mem_rd;
  logic [7:0] mem_addr, mem_wdata;
  logic sda_line;

  int total, bad, wr_cnt, rd_cnt;
  logic [7:0] last_addr, last_data;

  assign sda_line = sda_m & ~sda_oe;

  eewp_front uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .pin_lvl(pin_lvl), .pin_hv(pin_hv), .rev_prot(rev_prot),
    .perm_prot(perm_prot), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && mem_wr) begin
      wr_cnt++;
      last_addr = mem_addr;
      last_data = mem_wdata;
    end
    if (rst_n && mem_rd) rd_cnt++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl = 1'b1; wq(); scl = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl = 1'b1; wq();
    ack = ~sda_line;
    scl = 1'b0; wq();
  endtask

  // full three-byte protection write; returns acks of the three bytes
  task automatic prot_wr(input logic [7:0] a, output logic k0, output logic k1,
                         output logic k2);
    k1 = 1'b0; k2 = 1'b0;
    bus_start();
    send(a, k0);
    if (k0) begin
      send(8'h3C, k1);
      send(8'hC3, k2);
    end
    bus_stop();
  endtask

  // vector: {pin_lvl, pin_hv, address byte, expected ack}
  localparam logic [14:0] VEC [0:7] = '{
    {3'b101, 3'b000, 8'hAA, 1'b1},  // R2 match
    {3'b101, 3'b000, 8'hA8, 1'b0},  // R2 mismatch
    {3'b000, 3'b000, 8'hA1, 1'b1},  // R2 read
    {3'b000, 3'b000, 8'h50, 1'b0},  // R3
    {3'b000, 3'b000, 8'hE0, 1'b0},  // R3
    {3'b011, 3'b000, 8'h67, 1'b1},  // R9 perm status clear
    {3'b000, 3'b001, 8'h63, 1'b1},  // R9 rev status clear
    {3'b100, 3'b001, 8'h6B, 1'b0}   // R4 no valid pattern
  };

  initial begin
    logic k0, k1, k2, k3;
    total = 0; bad = 0; wr_cnt = 0; rd_cnt = 0;
    last_addr = '0; last_data = '0;
    scl = 1'b1; sda_m = 1'b1; pin_lvl = '0; pin_hv = '0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R13 reset state
    chk("R13 rev", int'(rev_prot), 0);
    chk("R13 perm", int'(perm_prot), 0);
    chk("R13 sda_oe", int'(sda_oe), 0);

    for (int v = 0; v < 8; v++) begin
      pin_lvl = VEC[v][14:12];
      pin_hv  = VEC[v][11:9];
      bus_start();
      send(VEC[v][8:1], k0);
      bus_stop();
      chk($sformatf("R2/R3/R9 vector %0d ack", v), int'(k0), int'(VEC[v][0]));
      chk("R12 released", int'(sda_oe), 0);
    end
    chk("R11 read strobe count", rd_cnt, 1);
    chk("R1 flags untouched", int'(rev_prot | perm_prot), 0);

    // R11 normal write with auto-increment
    pin_lvl = 3'b010; pin_hv = 3'b000;
    bus_start(); send(8'hA4, k0); send(8'h10, k1); send(8'h5A, k2); send(8'h3C, k3); bus_stop();
    chk("R11 acks", int'(k0 & k1 & k2 & k3), 1);
    chk("R11 wr count", wr_cnt, 2);
    chk("R11 addr", int'(last_addr), 'h11);
    chk("R11 data", int'(last_data), 'h3C);

    // R8 early stop and repeated start
    pin_lvl = 3'b000; pin_hv = 3'b001;
    bus_start(); send(8'h62, k0); send(8'h00, k1); bus_stop();
    chk("R8 early stop", int'(rev_prot), 0);
    bus_start(); send(8'h62, k0); send(8'h00, k1); bus_start(); bus_stop();
    chk("R8 repeated start", int'(rev_prot), 0);

    // R4 set reversible
    prot_wr(8'h62, k0, k1, k2);
    chk("R4 acks", int'(k0 & k1 & k2), 1);
    chk("R4 rev set", int'(rev_prot), 1);
    bus_start(); send(8'h63, k0); bus_stop();
    chk("R9 rev status set", int'(k0), 0);

    // R10 blocked lower half, open upper half
    pin_lvl = 3'b010; pin_hv = 3'b000;
    bus_start(); send(8'hA4, k0); send(8'h20, k1); send(8'h11, k2); bus_stop();
    chk("R10 low nack", int'(k2), 0);
    chk("R10 no strobe", wr_cnt, 2);
    bus_start(); send(8'hA4, k0); send(8'h80, k1); send(8'h22, k2); bus_stop();
    chk("R10 high ack", int'(k2), 1);
    chk("R10 high addr", int'(last_addr), 'h80);

    // R5 clear reversible
    pin_lvl = 3'b010; pin_hv = 3'b001;
    prot_wr(8'h66, k0, k1, k2);
    chk("R5 acks", int'(k0 & k1 & k2), 1);
    chk("R5 rev cleared", int'(rev_prot), 0);

    // R6 permanent, after reversible set again
    pin_lvl = 3'b000; pin_hv = 3'b001;
    prot_wr(8'h62, k0, k1, k2);
    pin_hv = 3'b000;
    prot_wr(8'h60, k0, k1, k2);
    chk("R6 acks", int'(k0 & k1 & k2), 1);
    chk("R6 perm set", int'(perm_prot), 1);
    bus_start(); send(8'h61, k0); bus_stop();
    chk("R9 perm status set", int'(k0), 0);

    // R7 locked out
    pin_lvl = 3'b010; pin_hv = 3'b001;
    prot_wr(8'h66, k0, k1, k2);
    chk("R7 clear refused", int'(k0), 0);
    chk("R7 rev kept", int'(rev_prot), 1);
    pin_lvl = 3'b000;
    prot_wr(8'h62, k0, k1, k2);
    chk("R7 set refused", int'(k0), 0);
    pin_hv = 3'b000;
    prot_wr(8'h60, k0, k1, k2);
    chk("R7 perm refused", int'(k0), 0);
    chk("R6 perm sticky", int'(perm_prot), 1);
    chk("R12 idle", int'(sda_oe), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule